// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block is the control unit of a small accumulator computer built around one shared data bus. It reads the 4-bit operation code held in the upper nibble of the instruction register and steps a counter through a fixed three-step fetch phase. An execute phase follows whose length depends on the operation. On each step it raises the control lines the datapath needs: which source drives the bus, which register loads from it, and the program counter increment, memory write, subtract select and halt request.

The fetch phase moves the program counter into the memory address register. It then moves the addressed memory word into the instruction register, and in a third step of its own increments the program counter. Each operation then performs a fixed list of bus transfers and the counter wraps to the first fetch step. A halt operation sets a sticky flag that stops the sequencer until synchronous reset. The datapath registers, memory and ALU sit outside this block.

Top module: `acc_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `step` = 0 with `halted` = 0. In step 0, `drv_pc` and `ld_mar` are the only asserted controls.
- R2: Fetch uses steps 0, 1 and 2. Step 0 asserts `drv_pc`+`ld_mar`, step 1 asserts `drv_ram`+`ld_ir`, and step 2 asserts only `pc_inc`. Execute steps are numbered from 3 upward.
- R3: Opcode 0001 (load) executes as step 3 `drv_irlo`+`ld_mar`, then step 4 `drv_ram`+`ld_acc`.
- R4: Opcode 0010 (add) executes as step 3 `drv_irlo`+`ld_mar`, step 4 `drv_ram`+`ld_b`, and step 5 `drv_alu`+`ld_acc`. Opcode 0011 (subtract) is identical except that `alu_sub` is also asserted in step 5.
- R5: Opcode 0100 (store) executes as step 3 `drv_irlo`+`ld_mar`, then step 4 `drv_acc`+`ram_we`.
- R6: Opcode 0101 (load immediate) executes one step, `drv_irlo`+`ld_acc`. Opcode 0110 (jump) executes one step, `drv_irlo`+`ld_pc`.
- R7: Opcode 1110 (output) executes one step, `drv_acc`+`ld_out`.
- R8: Opcode 0000, and every code not named in R3 to R7 or R10, has no execute steps. The step after fetch step 2 is step 0.
- R9: The step after an operation's last execute step is step 0.
- R10: Opcode 1111 executes one step in which only `halt_req` is asserted. From the next cycle, `halted` is 1, `step` holds at 0 and every control output is 0, whatever the opcode, until reset.
- R11: At most one bus-drive output is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Upper nibble of the instruction register |
| step | output | STEP_W | Current step number |
| drv_pc | output | 1 | Program counter drives the bus |
| drv_ram | output | 1 | Memory drives the bus |
| drv_irlo | output | 1 | Instruction low nibble drives the bus |
| drv_acc | output | 1 | Accumulator drives the bus |
| drv_alu | output | 1 | ALU result drives the bus |
| ld_mar | output | 1 | Memory address register loads from the bus |
| ld_ir | output | 1 | Instruction register loads from the bus |
| ld_acc | output | 1 | Accumulator loads from the bus |
| ld_b | output | 1 | B operand register loads from the bus |
| ld_out | output | 1 | Output register loads from the bus |
| ld_pc | output | 1 | Program counter loads from the bus |
| pc_inc | output | 1 | Program counter increments |
| ram_we | output | 1 | Memory writes the bus value |
| alu_sub | output | 1 | ALU subtracts instead of adding |
| halt_req | output | 1 | Halt operation is executing |
| halted | output | 1 | Sticky halt flag |

## Verification
The control outputs decode combinationally from the registered step and the present opcode, so a step's control word is valid in the same cycle that step is shown. The step register and halt flag move one rising edge after the condition that causes the change. The bench sets the opcode and samples on falling edges, so each falling edge shows exactly one step. It compares that step's number and whole control word with its own table. The wrap to step 0 is checked at the falling edge after the last execute step. The halt flag and the frozen state are checked from the falling edge after the halt step, and the reset state is checked one edge after reset is seen.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OP_W      = 4;
  localparam int FETCH_N   = 3;

  localparam logic [OP_W-1:0] OP_NOP = 4'b0000;
  localparam logic [OP_W-1:0] OP_LDM = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADM = 4'b0010;
  localparam logic [OP_W-1:0] OP_SBM = 4'b0011;
  localparam logic [OP_W-1:0] OP_STM = 4'b0100;
  localparam logic [OP_W-1:0] OP_LDK = 4'b0101;
  localparam logic [OP_W-1:0] OP_JMP = 4'b0110;
  localparam logic [OP_W-1:0] OP_SHW = 4'b1110;
  localparam logic [OP_W-1:0] OP_STP = 4'b1111;

  typedef struct packed {
    logic drv_pc;
    logic drv_ram;
    logic drv_irlo;
    logic drv_acc;
    logic drv_alu;
    logic ld_mar;
    logic ld_ir;
    logic ld_acc;
    logic ld_b;
    logic ld_out;
    logic ld_pc;
    logic pc_inc;
    logic ram_we;
    logic alu_sub;
    logic halt_req;
  } ctrl_t;

  // Number of execute steps for an operation; unknown codes take none.
  function automatic int unsigned exec_len(input logic [OP_W-1:0] op);
    case (op)
      OP_ADM, OP_SBM:         return 3;
      OP_LDM, OP_STM:         return 2;
      OP_LDK, OP_JMP, OP_SHW,
      OP_STP:                 return 1;
      default:                return 0;
    endcase
  endfunction

  // Control word of fetch step idx (0..FETCH_N-1).
  function automatic ctrl_t fetch_word(input int unsigned idx);
    ctrl_t c;
    c = '0;
    case (idx)
      0:       begin c.drv_pc  = 1'b1; c.ld_mar = 1'b1; end
      1:       begin c.drv_ram = 1'b1; c.ld_ir  = 1'b1; end
      default: c.pc_inc = 1'b1;
    endcase
    return c;
  endfunction

  // Control word of execute step idx for operation op.
  function automatic ctrl_t exec_word(input logic [OP_W-1:0] op,
                                      input int unsigned idx);
    ctrl_t c;
    c = '0;
    case (op)
      OP_LDM, OP_ADM, OP_SBM, OP_STM:
        if (idx == 0) begin
          c.drv_irlo = 1'b1;
          c.ld_mar   = 1'b1;
        end else if (idx == 1) begin
          if (op == OP_STM) begin
            c.drv_acc = 1'b1;
            c.ram_we  = 1'b1;
          end else begin
            c.drv_ram = 1'b1;
            c.ld_acc  = (op == OP_LDM);
            c.ld_b    = (op != OP_LDM);
          end
        end else begin
          c.drv_alu = 1'b1;
          c.ld_acc  = 1'b1;
          c.alu_sub = (op == OP_SBM);
        end
      OP_LDK:  begin c.drv_irlo = 1'b1; c.ld_acc = 1'b1; end
      OP_JMP:  begin c.drv_irlo = 1'b1; c.ld_pc  = 1'b1; end
      OP_SHW:  begin c.drv_acc  = 1'b1; c.ld_out = 1'b1; end
      OP_STP:  c.halt_req = 1'b1;
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/acc_seq_stepper.sv
module acc_seq_stepper
  import acc_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [OP_W-1:0]   opcode,
  output logic [STEP_W-1:0] step,
  output logic              instr_done
);

  logic [STEP_W-1:0] last_step;

  assign last_step  = STEP_W'(FETCH_N - 1 + exec_len(opcode));
  assign instr_done = !hold && (step == last_step);

  always_ff @(posedge clk) begin
    if (rst)
      step <= '0;
    else if (hold)
      step <= step;
    else if (instr_done)
      step <= '0;
    else
      step <= step + 1'b1;
  end

endmodule

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step,
  input  logic [OP_W-1:0]   opcode,
  input  logic              halted,
  output ctrl_t             ctrl
);

  localparam logic [STEP_W-1:0] EXEC_BASE = STEP_W'(FETCH_N);

  always_comb begin
    if (halted)
      ctrl = '0;
    else if (step < EXEC_BASE)
      ctrl = fetch_word(int'(step));
    else
      ctrl = exec_word(opcode, int'(step - EXEC_BASE));
  end

endmodule

// File: rtl/acc_seq_haltlatch.sv
module acc_seq_haltlatch (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  output logic halted
);

  always_ff @(posedge clk) begin
    if (rst)
      halted <= 1'b0;
    else if (set_req)
      halted <= 1'b1;
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        opcode,
  output logic [STEP_W-1:0] step,
  output logic              drv_pc,
  output logic              drv_ram,
  output logic              drv_irlo,
  output logic              drv_acc,
  output logic              drv_alu,
  output logic              ld_mar,
  output logic              ld_ir,
  output logic              ld_acc,
  output logic              ld_b,
  output logic              ld_out,
  output logic              ld_pc,
  output logic              pc_inc,
  output logic              ram_we,
  output logic              alu_sub,
  output logic              halt_req,
  output logic              halted
);

  ctrl_t ctrl;
  logic  instr_done;

  acc_seq_stepper #(.STEP_W(STEP_W)) u_step (
    .clk        (clk),
    .rst        (rst),
    .hold       (halted),
    .opcode     (opcode),
    .step       (step),
    .instr_done (instr_done)
  );

  acc_seq_decode #(.STEP_W(STEP_W)) u_dec (
    .step   (step),
    .opcode (opcode),
    .halted (halted),
    .ctrl   (ctrl)
  );

  acc_seq_haltlatch u_halt (
    .clk     (clk),
    .rst     (rst),
    .set_req (ctrl.halt_req),
    .halted  (halted)
  );

  assign drv_pc   = ctrl.drv_pc;
  assign drv_ram  = ctrl.drv_ram;
  assign drv_irlo = ctrl.drv_irlo;
  assign drv_acc  = ctrl.drv_acc;
  assign drv_alu  = ctrl.drv_alu;
  assign ld_mar   = ctrl.ld_mar;
  assign ld_ir    = ctrl.ld_ir;
  assign ld_acc   = ctrl.ld_acc;
  assign ld_b     = ctrl.ld_b;
  assign ld_out   = ctrl.ld_out;
  assign ld_pc    = ctrl.ld_pc;
  assign pc_inc   = ctrl.pc_inc;
  assign ram_we   = ctrl.ram_we;
  assign alu_sub  = ctrl.alu_sub;
  assign halt_req = ctrl.halt_req;

endmodule

// File: rtl/acc_seq_checker.sv
module acc_seq_checker #(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [STEP_W-1:0] step,
  input logic [4:0]        drivers,
  input logic [9:0]        others,
  input logic              halted,
  input logic              instr_done
);

  a_r11_one_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drivers));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (step == '0) && !halted);

  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(step));

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> (drivers == '0) && (others == '0));

  a_r2_fetch_advance: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_W'(0)) && !halted |=> step == STEP_W'(1));

  a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> step == '0);

endmodule

bind acc_seq acc_seq_checker #(.STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step       (step),
  .drivers    ({drv_pc, drv_ram, drv_irlo, drv_acc, drv_alu}),
  .others     ({ld_mar, ld_ir, ld_acc, ld_b, ld_out, ld_pc,
                pc_inc, ram_we, alu_sub, halt_req}),
  .halted     (halted),
  .instr_done (instr_done)
);

// File: tb/acc_seq_test.sv
module acc_seq_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] opcode;
  logic [2:0] step;
  logic drv_pc, drv_ram, drv_irlo, drv_acc, drv_alu;
  logic ld_mar, ld_ir, ld_acc, ld_b, ld_out, ld_pc;
  logic pc_inc, ram_we, alu_sub, halt_req, halted;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  acc_seq uut (
    .clk(clk), .rst(rst), .opcode(opcode), .step(step),
    .drv_pc(drv_pc), .drv_ram(drv_ram), .drv_irlo(drv_irlo),
    .drv_acc(drv_acc), .drv_alu(drv_alu), .ld_mar(ld_mar), .ld_ir(ld_ir),
    .ld_acc(ld_acc), .ld_b(ld_b), .ld_out(ld_out), .ld_pc(ld_pc),
    .pc_inc(pc_inc), .ram_we(ram_we), .alu_sub(alu_sub),
    .halt_req(halt_req), .halted(halted)
  );

  localparam logic [14:0] DPC = 15'(1) << 14, DRAM = 15'(1) << 13,
    DIR = 15'(1) << 12, DACC = 15'(1) << 11, DALU = 15'(1) << 10,
    LMAR = 15'(1) << 9, LIR = 15'(1) << 8, LACC = 15'(1) << 7,
    LB = 15'(1) << 6, LOUT = 15'(1) << 5, LPC = 15'(1) << 4,
    INC = 15'(1) << 3, WE = 15'(1) << 2, SUBS = 15'(1) << 1, HREQ = 15'(1);

  localparam logic [14:0] F0 = DPC | LMAR, F1 = DRAM | LIR, F2 = INC;

  // {opcode, execute steps, word 3, word 4, word 5}
  localparam int NV = 11;
  localparam logic [50:0] VEC [NV] = '{
    {4'b0001, 2'd2, DIR | LMAR, DRAM | LACC, 15'd0},           // R3
    {4'b0010, 2'd3, DIR | LMAR, DRAM | LB, DALU | LACC},       // R4
    {4'b0011, 2'd3, DIR | LMAR, DRAM | LB, DALU | LACC | SUBS},// R4
    {4'b0100, 2'd2, DIR | LMAR, DACC | WE, 15'd0},             // R5
    {4'b0101, 2'd1, DIR | LACC, 15'd0, 15'd0},                 // R6
    {4'b0110, 2'd1, DIR | LPC, 15'd0, 15'd0},                  // R6
    {4'b1110, 2'd1, DACC | LOUT, 15'd0, 15'd0},                // R7
    {4'b0000, 2'd0, 15'd0, 15'd0, 15'd0},                      // R8
    {4'b0111, 2'd0, 15'd0, 15'd0, 15'd0},                      // R8
    {4'b1010, 2'd0, 15'd0, 15'd0, 15'd0},                      // R8
    {4'b0010, 2'd3, DIR | LMAR, DRAM | LB, DALU | LACC}        // R4 again
  };

  function automatic logic [14:0] word_now();
    return {drv_pc, drv_ram, drv_irlo, drv_acc, drv_alu, ld_mar, ld_ir,
            ld_acc, ld_b, ld_out, ld_pc, pc_inc, ram_we, alu_sub, halt_req};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [2:0] s,
                             input logic [14:0] w, input logic h);
    check(req, "step", 32'(step), 32'(s));
    check(req, "controls", 32'(word_now()), 32'(w));
    check(req, "halted", 32'(halted), 32'(h));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    opcode = 4'b0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_state("R1", 3'd0, F0, 1'b0);

    // table walk: fetch, execute, wrap
    for (int v = 0; v < NV; v++) begin
      logic [50:0] e;
      int n;
      e = VEC[v];
      n = int'(e[46:45]);
      opcode = e[50:47];
      check_state("R2", 3'd0, F0, 1'b0);
      @(negedge clk);
      check_state("R2", 3'd1, F1, 1'b0);
      @(negedge clk);
      check_state("R2", 3'd2, F2, 1'b0);
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        check_state("R3-R7 exec", 3'(3 + k), e[44 - 15*k -: 15], 1'b0);
      end
      @(negedge clk);
      check_state(n == 0 ? "R8" : "R9", 3'd0, F0, 1'b0);
    end

    // reset in the middle of a subtract
    opcode = 4'b0011;
    repeat (4) @(negedge clk);
    check("R4", "mid step", 32'(step), 32'd4);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_state("R1", 3'd0, F0, 1'b0);

    // halt
    opcode = 4'b1111;
    repeat (3) @(negedge clk);
    check_state("R10", 3'd3, HREQ, 1'b0);
    @(negedge clk);
    check_state("R10", 3'd0, 15'd0, 1'b1);
    opcode = 4'b0001;
    repeat (5) @(negedge clk);
    check_state("R10", 3'd0, 15'd0, 1'b1);
    opcode = 4'b0010;
    @(negedge clk);
    check_state("R10", 3'd0, 15'd0, 1'b1);

    // reset releases the halt
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_state("R1", 3'd0, F0, 1'b0);
    @(negedge clk);
    check_state("R2", 3'd1, F1, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule